// File: doc/BRIEF.md
# AHB-Lite Register Slave with Access Rejection

This block is an AHB-Lite slave that holds a small bank of 32-bit registers. Each register has three fixed attributes: whether it can be written, which transfer sizes it accepts, and whether it needs a privileged master. The slave registers each address phase it is given. In the following data phase it either serves the access with no wait states or refuses it.

A refused access gets the protocol's two-cycle ERROR response and has no side effect. An access is refused when it writes a read-only register, uses a size the register does not accept, or lacks the privilege the register demands. The bus therefore never hangs on a bad access, and the bad access is never hidden behind an OKAY. Address decoding is done upstream. The slave trusts its select input and uses the low address bits as a register index.

Top module: `ahb_guarded_regs`

## Requirements
- R1: After a synchronous reset, `hreadyout` is 1 and `hresp` is 0 (OKAY). Register n holds `32'h5A00_0000 | (n << 8) | n`.
- R2: A legal read completes in its data phase (the cycle after the address phase) with `hreadyout`=1 and `hresp`=0. `hrdata` carries the whole 32-bit word of the register indexed by `haddr[IDX_W+1:2]`, whatever the size.
- R3: A legal write completes with zero wait states and OKAY. It updates only the byte lanes its size selects: size 0 selects the lane `haddr[1:0]`, size 1 selects lanes 1:0 or 3:2 by `haddr[1]`, and size 2 selects all four. The data is taken from `hwdata` in the data phase.
- R4: A write (`hwrite`=1) to a read-only register is refused with ERROR.
- R5: An access whose `hsize` the register does not accept is refused with ERROR. Encodings are 0 byte, 1 halfword and 2 word; values of 3 and above are refused by every register.
- R6: An access with `hprot[1]`=0 (unprivileged) to a register that needs privilege is refused with ERROR. `hprot[1]`=1 marks a privileged access.
- R7: An ERROR takes two cycles: first `hresp`=1 with `hreadyout`=0, then `hresp`=1 with `hreadyout`=1. Only one such pair is produced when several refusal causes hold together. A transfer offered in the second cycle is accepted; one offered in the first cycle is ignored.
- R8: A refused access changes no register.
- R9: Cycles with `htrans` IDLE (2'b00) or BUSY (2'b01), or with `hsel` low, get a zero-wait OKAY and change no register. NONSEQ is 2'b10 and SEQ is 2'b11.
- R10: Attributes repeat every eight indices, by index mod 8:
  - 0: writable, all sizes.
  - 1: read-only, all sizes.
  - 2: writable, byte only.
  - 3: writable, word only, privileged.
  - 4: read-only, all sizes, privileged.
  - 5: writable, halfword and word.
  - 6: writable, all sizes, privileged.
  - 7: read-only, word only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select from the upstream decoder |
| htrans | input | 2 | Transfer type |
| haddr | input | ADDR_W | Byte address |
| hwrite | input | 1 | 1 for a write |
| hsize | input | 3 | Transfer size |
| hprot | input | 4 | Protection bits; bit 1 is privilege |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus-wide ready (previous transfer done) |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The hardest case to reach is a new transfer arriving while an ERROR is still in progress. A master that does not cancel its follow-on transfer presents it in the second ERROR cycle, and that transfer must be captured. A transfer presented in the first ERROR cycle must instead be dropped. The bench drives both cases by hand, cycle by cycle, and reads the target register back afterwards to confirm what was and was not applied. Accesses that trip two refusal causes at once are also in the table, to show that they produce a single two-cycle ERROR.

// File: rtl/agr_pkg.sv
package agr_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    // per-register attributes; sizes[k] set means hsize==k is accepted
    typedef struct packed {
        logic       ro;
        logic       priv;
        logic [2:0] sizes;
    } reg_attr_t;

    typedef enum logic {
        RS_IDLE     = 1'b0,
        RS_ERR_TAIL = 1'b1
    } rsp_state_e;

    function automatic reg_attr_t attr_of(input int unsigned idx);
        reg_attr_t a;
        case (idx % 32'd8)
            32'd0:   a = '{ro: 1'b0, priv: 1'b0, sizes: 3'b111};
            32'd1:   a = '{ro: 1'b1, priv: 1'b0, sizes: 3'b111};
            32'd2:   a = '{ro: 1'b0, priv: 1'b0, sizes: 3'b001};
            32'd3:   a = '{ro: 1'b0, priv: 1'b1, sizes: 3'b100};
            32'd4:   a = '{ro: 1'b1, priv: 1'b1, sizes: 3'b111};
            32'd5:   a = '{ro: 1'b0, priv: 1'b0, sizes: 3'b110};
            32'd6:   a = '{ro: 1'b0, priv: 1'b1, sizes: 3'b111};
            default: a = '{ro: 1'b1, priv: 1'b0, sizes: 3'b100};
        endcase
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] reset_of(input int unsigned idx);
        logic [DATA_W-1:0] v;
        v = 32'h5A00_0000 | (32'(idx & 32'hFF) << 8) | 32'(idx & 32'hFF);
        return v;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size,
                                                   input logic [1:0] off);
        logic [LANES-1:0] m;
        case (size)
            3'd0:    m = 4'b0001 << off;
            3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic size_ok(input reg_attr_t a, input logic [2:0] size);
        return (size <= 3'd2) && a.sizes[size[1:0]];
    endfunction

endpackage

// File: rtl/agr_addr_phase.sv
module agr_addr_phase #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [3:0]        hprot,
    input  logic              hready_in,
    output logic              ph_valid,
    output logic              ph_write,
    output logic [IDX_W-1:0]  ph_idx,
    output logic [2:0]        ph_size,
    output logic [1:0]        ph_off,
    output logic              ph_priv
);
    logic unused_bits;
    assign unused_bits = ^{haddr[ADDR_W-1:IDX_W+2], hprot[3:2], hprot[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_valid <= 1'b0;
            ph_write <= 1'b0;
            ph_idx   <= '0;
            ph_size  <= '0;
            ph_off   <= '0;
            ph_priv  <= 1'b0;
        end else if (hready_in) begin
            ph_valid <= hsel && htrans[1];
            ph_write <= hwrite;
            ph_idx   <= haddr[IDX_W+1:2];
            ph_size  <= hsize;
            ph_off   <= haddr[1:0];
            ph_priv  <= hprot[1];
        end
    end
endmodule

// File: rtl/agr_attr_check.sv
module agr_attr_check
    import agr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic             ph_valid,
    input  logic             ph_write,
    input  logic [IDX_W-1:0] ph_idx,
    input  logic [2:0]       ph_size,
    input  logic             ph_priv,
    output logic             reject
);
    localparam int SLOTS = 2 ** IDX_W;

    reg_attr_t attr_tab [SLOTS];
    logic      present  [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_tab
        if (g < NUM_REGS) begin : g_real
            assign attr_tab[g] = attr_of(g);
            assign present[g]  = 1'b1;
        end else begin : g_hole
            assign attr_tab[g] = '{ro: 1'b1, priv: 1'b1, sizes: 3'b000};
            assign present[g]  = 1'b0;
        end
    end

    reg_attr_t cur;
    logic      bad_ro, bad_size, bad_priv, bad_hole;

    always_comb begin
        cur      = attr_tab[ph_idx];
        bad_hole = !present[ph_idx];
        bad_ro   = ph_write && cur.ro;
        bad_size = !size_ok(cur, ph_size);
        bad_priv = cur.priv && !ph_priv;
        reject   = ph_valid && (bad_hole || bad_ro || bad_size || bad_priv);
    end
endmodule

// File: rtl/agr_resp_ctrl.sv
module agr_resp_ctrl
    import agr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph_valid,
    input  logic reject,
    output logic hreadyout,
    output logic hresp,
    output logic data_go
);
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d   = RS_IDLE;
        hreadyout = 1'b1;
        hresp     = RESP_OKAY;
        data_go   = 1'b0;
        case (state_q)
            RS_IDLE: begin
                if (ph_valid && reject) begin
                    hreadyout = 1'b0;
                    hresp     = RESP_ERROR;
                    state_d   = RS_ERR_TAIL;
                end else begin
                    data_go = ph_valid;
                end
            end
            RS_ERR_TAIL: begin
                hresp   = RESP_ERROR;
                state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RS_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/agr_reg_bank.sv
module agr_reg_bank
    import agr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [LANES-1:0]           wr_strb,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam int SLOTS = 2 ** IDX_W;

    logic [DATA_W-1:0] rd_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_reg
        if (g < NUM_REGS) begin : g_real
            localparam reg_attr_t        A  = attr_of(g);
            localparam logic [DATA_W-1:0] RV = reset_of(g);
            if (A.ro) begin : g_const
                assign rd_arr[g] = RV;
            end else begin : g_store
                logic [DATA_W-1:0] q;
                logic              hit;
                assign hit = wr_en && (wr_idx == IDX_W'(g));
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= RV;
                    end else if (hit) begin
                        for (int l = 0; l < LANES; l++) begin
                            if (wr_strb[l]) q[8*l +: 8] <= wr_data[8*l +: 8];
                        end
                    end
                end
                assign rd_arr[g] = q;
            end
            assign regs_flat[g*DATA_W +: DATA_W] = rd_arr[g];
        end else begin : g_hole
            assign rd_arr[g] = '0;
        end
    end

    assign rd_data = rd_arr[rd_idx];
endmodule

// File: rtl/ahb_guarded_regs.sv
module ahb_guarded_regs
    import agr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [3:0]        hprot,
    input  logic [31:0]       hwdata,
    input  logic              hready_in,
    output logic [31:0]       hrdata,
    output logic              hreadyout,
    output logic              hresp
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              ph_valid, ph_write, ph_priv;
    logic [IDX_W-1:0]  ph_idx;
    logic [2:0]        ph_size;
    logic [1:0]        ph_off;
    logic              reject, data_go;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    agr_addr_phase #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .haddr(haddr),
        .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hready_in(hready_in),
        .ph_valid(ph_valid), .ph_write(ph_write), .ph_idx(ph_idx),
        .ph_size(ph_size), .ph_off(ph_off), .ph_priv(ph_priv)
    );

    agr_attr_check #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_check (
        .ph_valid(ph_valid), .ph_write(ph_write), .ph_idx(ph_idx),
        .ph_size(ph_size), .ph_priv(ph_priv), .reject(reject)
    );

    agr_resp_ctrl u_resp (
        .clk(clk), .rst(rst), .ph_valid(ph_valid), .reject(reject),
        .hreadyout(hreadyout), .hresp(hresp), .data_go(data_go)
    );

    agr_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(data_go && ph_write), .wr_idx(ph_idx),
        .wr_strb(lane_mask(ph_size, ph_off)), .wr_data(hwdata),
        .rd_idx(ph_idx), .rd_data(rd_data), .regs_flat(regs_flat)
    );

    assign hrdata = (data_go && !ph_write) ? rd_data : '0;
endmodule

// File: rtl/agr_checker.sv
module agr_checker
    import agr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       hsel,
    input logic [1:0]                 htrans,
    input logic [ADDR_W-1:0]          haddr,
    input logic                       hwrite,
    input logic [2:0]                 hsize,
    input logic [3:0]                 hprot,
    input logic                       hready_in,
    input logic                       hreadyout,
    input logic                       hresp,
    input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic unused_chk;
    assign unused_chk = ^{haddr[ADDR_W-1:IDX_W+2], haddr[1:0], hprot[3:2], hprot[0]};

    logic             acc, in_rng, legal;
    logic [IDX_W-1:0] a_idx;
    reg_attr_t        cur;

    assign acc   = hsel && htrans[1] && hready_in;
    assign a_idx = haddr[IDX_W+1:2];
    assign cur   = attr_of(32'(a_idx));

    if (NUM_REGS == 2 ** IDX_W) begin : g_full
        assign in_rng = 1'b1;
    end else begin : g_part
        assign in_rng = 32'(a_idx) < NUM_REGS;
    end

    assign legal = in_rng && !(hwrite && cur.ro) && size_ok(cur, hsize)
                   && !(cur.priv && !hprot[1]);

    // R2: legal accepted access is served next cycle without wait
    a_r2_zero_wait: assert property (@(posedge clk) disable iff (rst)
        (acc && legal) |=> (hreadyout && !hresp));
    // R4
    a_r4_ro_write: assert property (@(posedge clk) disable iff (rst)
        (acc && in_rng && hwrite && cur.ro) |=> (hresp && !hreadyout));
    // R5
    a_r5_bad_size: assert property (@(posedge clk) disable iff (rst)
        (acc && in_rng && !size_ok(cur, hsize)) |=> (hresp && !hreadyout));
    // R6
    a_r6_no_priv: assert property (@(posedge clk) disable iff (rst)
        (acc && in_rng && cur.priv && !hprot[1]) |=> (hresp && !hreadyout));
    // R7: second error cycle follows the first
    a_r7_err_tail: assert property (@(posedge clk) disable iff (rst)
        (hresp && !hreadyout) |=> (hresp && hreadyout));
    // R7: never more than one stalled cycle
    a_r7_no_hang: assert property (@(posedge clk) disable iff (rst)
        (!hreadyout) |=> hreadyout);
    // R8: the edge that ends the first error cycle commits nothing
    a_r8_no_effect: assert property (@(posedge clk) disable iff (rst)
        (hresp && !hreadyout) |=> $stable(regs_flat));
    // R9
    a_r9_idle_okay: assert property (@(posedge clk) disable iff (rst)
        (hready_in && hreadyout && !acc) |=> (hreadyout && !hresp));
endmodule

bind ahb_guarded_regs agr_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_agr_checker (
    .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hready_in(hready_in),
    .hreadyout(hreadyout), .hresp(hresp), .regs_flat(regs_flat)
);

// File: tb/ahb_guarded_regs_bench.sv
module ahb_guarded_regs_bench;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [2:0]  size;
        logic [11:0] addr;
        logic        priv;
        logic [31:0] wdata;
        logic        err;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 1'b1, 3'd2, 12'h000, 1'b0, 32'h1122_3344, 1'b0},
        '{4'd2, 1'b0, 3'd2, 12'h000, 1'b0, 32'h0,         1'b0},
        '{4'd4, 1'b1, 3'd2, 12'h004, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{4'd8, 1'b0, 3'd2, 12'h004, 1'b0, 32'h0,         1'b0},
        '{4'd3, 1'b1, 3'd0, 12'h009, 1'b0, 32'h0000_AB00, 1'b0},
        '{4'd2, 1'b0, 3'd0, 12'h008, 1'b0, 32'h0,         1'b0},
        '{4'd5, 1'b1, 3'd1, 12'h008, 1'b0, 32'h7777_7777, 1'b1},
        '{4'd5, 1'b0, 3'd2, 12'h008, 1'b0, 32'h0,         1'b1},
        '{4'd8, 1'b0, 3'd0, 12'h00B, 1'b0, 32'h0,         1'b0},
        '{4'd3, 1'b1, 3'd2, 12'h00C, 1'b1, 32'hCAFE_F00D, 1'b0},
        '{4'd6, 1'b1, 3'd2, 12'h00C, 1'b0, 32'h0BAD_BEEF, 1'b1},
        '{4'd8, 1'b0, 3'd2, 12'h00C, 1'b1, 32'h0,         1'b0},
        '{4'd6, 1'b0, 3'd2, 12'h010, 1'b0, 32'h0,         1'b1},
        '{4'd2, 1'b0, 3'd2, 12'h010, 1'b1, 32'h0,         1'b0},
        '{4'd7, 1'b1, 3'd2, 12'h010, 1'b0, 32'h1234_5678, 1'b1},
        '{4'd8, 1'b0, 3'd1, 12'h012, 1'b1, 32'h0,         1'b0},
        '{4'd3, 1'b1, 3'd1, 12'h016, 1'b0, 32'hDEAD_0000, 1'b0},
        '{4'd2, 1'b0, 3'd1, 12'h014, 1'b0, 32'h0,         1'b0},
        '{4'd5, 1'b0, 3'd0, 12'h014, 1'b0, 32'h0,         1'b1},
        '{4'd3, 1'b1, 3'd2, 12'h018, 1'b1, 32'hA5A5_A5A5, 1'b0},
        '{4'd6, 1'b0, 3'd2, 12'h018, 1'b0, 32'h0,         1'b1},
        '{4'd5, 1'b0, 3'd3, 12'h000, 1'b0, 32'h0,         1'b1},
        '{4'd7, 1'b1, 3'd0, 12'h01C, 1'b0, 32'h0000_00EE, 1'b1},
        '{4'd8, 1'b0, 3'd2, 12'h01C, 1'b0, 32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        hsel;
    logic [1:0]  htrans;
    logic [11:0] haddr;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [3:0]  hprot;
    logic [31:0] hwdata;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    ahb_guarded_regs u_ahb_guarded_regs (
        .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .haddr(haddr),
        .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
        .hready_in(hreadyout), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic bus_idle();
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
    endtask

    task automatic apply_write(input logic [2:0] size, input logic [11:0] addr,
                               input logic [31:0] wdata);
        logic [3:0] m;
        case (size)
            3'd0:    m = 4'b0001 << addr[1:0];
            3'd1:    m = addr[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        for (int b = 0; b < 4; b++)
            if (m[b]) model[addr[4:2]][8*b +: 8] = wdata[8*b +: 8];
    endtask

    // one single transfer: address phase, then data phase, sampled at negedges
    task automatic run_vec(input vec_t v);
        string r;
        r = req_name(v.req);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = v.addr; hwrite = v.wr;
        hsize = v.size; hprot = {2'b00, v.priv, 1'b1};
        @(negedge clk);
        bus_idle();
        hwdata = v.wdata;
        if (v.err) begin
            check(hresp && !hreadyout, r, "error cycle 1 {hresp,hready}",
                  {30'd0, hresp, hreadyout}, 32'h2);
            @(negedge clk);
            check(hresp && hreadyout, "R7", "error cycle 2 {hresp,hready}",
                  {30'd0, hresp, hreadyout}, 32'h3);
            @(negedge clk);
            check(!hresp && hreadyout, "R7", "after error {hresp,hready}",
                  {30'd0, hresp, hreadyout}, 32'h1);
        end else begin
            check(!hresp && hreadyout, r, "zero-wait OKAY {hresp,hready}",
                  {30'd0, hresp, hreadyout}, 32'h1);
            if (v.wr) apply_write(v.size, v.addr, v.wdata);
            else check(hrdata == model[v.addr[4:2]], r, "read data",
                       hrdata, model[v.addr[4:2]]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got=%h exp=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        vec_t v;
        rst = 1'b1; bus_idle(); haddr = '0; hsize = 3'd2; hprot = 4'b0011; hwdata = '0;
        for (int i = 0; i < 8; i++)
            model[i] = 32'h5A00_0000 | (32'(i) << 8) | 32'(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: outputs and contents after reset
        check(hreadyout && !hresp, "R1", "reset {hresp,hready}",
              {30'd0, hresp, hreadyout}, 32'h1);
        for (int i = 0; i < 8; i++) begin
            v = '{4'd2, 1'b0, (i == 2) ? 3'd0 : 3'd2, 12'(i * 4), 1'b1, 32'h0, 1'b0};
            run_vec(v); // R1 reset values read back
        end

        // table walk: R2..R8, R10 attribute map
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R9: BUSY with hsel high, then NONSEQ with hsel low, both writes to reg 0
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b01; hwrite = 1'b1; haddr = 12'h000; hsize = 3'd2; hprot = 4'b0011;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b10; hwdata = 32'hFFFF_FFFF;
        check(hreadyout && !hresp, "R9", "BUSY gets OKAY", {30'd0, hresp, hreadyout}, 32'h1);
        @(negedge clk);
        bus_idle(); hwdata = 32'hEEEE_EEEE;
        check(hreadyout && !hresp, "R9", "unselected gets OKAY", {30'd0, hresp, hreadyout}, 32'h1);
        run_vec('{4'd9, 1'b0, 3'd2, 12'h000, 1'b0, 32'h0, 1'b0}); // R9 reg 0 untouched

        // R7: follow-on offered in the second error cycle is served
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 12'h004; hsize = 3'd2; hprot = 4'b0011;
        @(negedge clk);
        bus_idle();
        check(hresp && !hreadyout, "R7", "RO write cycle 1", {30'd0, hresp, hreadyout}, 32'h2);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = 12'h000;
        check(hresp && hreadyout, "R7", "RO write cycle 2", {30'd0, hresp, hreadyout}, 32'h3);
        @(negedge clk);
        bus_idle();
        check(!hresp && hreadyout && hrdata == model[0], "R7", "follow-on read data",
              hrdata, model[0]);

        // R7: write offered during the first error cycle is dropped
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 12'h01C; hsize = 3'd0; hprot = 4'b0011;
        @(negedge clk);
        haddr = 12'h000; hsize = 3'd2; hwdata = 32'h0;
        check(hresp && !hreadyout, "R7", "RO+size error cycle 1", {30'd0, hresp, hreadyout}, 32'h2);
        @(negedge clk);
        bus_idle(); hwdata = 32'h9999_9999;
        check(hresp && hreadyout, "R7", "RO+size error cycle 2", {30'd0, hresp, hreadyout}, 32'h3);
        @(negedge clk);
        check(!hresp && hreadyout, "R7", "no phantom transfer", {30'd0, hresp, hreadyout}, 32'h1);
        run_vec('{4'd7, 1'b0, 3'd2, 12'h000, 1'b0, 32'h0, 1'b0}); // R7 reg 0 unchanged

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule